// File: doc/BRIEF.md
# Screen-Tile Primitive Distributor

The distributor sits between primitive setup and a set of backend pixel pipes. Each cycle it may accept one primitive, given as an identifier and a screen-space bounding box. It converts the box into a range of square screen tiles and walks that range row by row, one tile per cycle. For every tile the box overlaps, it writes one work entry into the input FIFO of the pipe that owns the tile. Each pipe drains its own FIFO at its own pace, so one pipe can run many primitives ahead of another.

The tile edge is a power of two chosen through a small configuration write, and it is 16 pixels after reset. Pipe ownership is a diagonal interleave of tile coordinates. In a multi-chip split-frame system, a second and coarser interleave over supertiles decides which chip owns each tile. Tiles owned by other chips are skipped without being written. When the walk reaches a tile whose pipe FIFO is full, it waits on that tile. Input ready stays low for as long as a walk is in progress.

Top module: `tile_distributor`

## Requirements
- R1: After reset, in_ready is 1, every pipe_valid bit is 0, and the tile edge is 16 pixels (log2 value 4).
- R2: An accepted box yields exactly one entry for each tile from (min_x>>s, min_y>>s) to (max_x'>>s, max_y'>>s). Here s is the tile log2, and max_x' and max_y' are the maximum coordinates clamped to SCREEN_W-1 and SCREEN_H-1. No tile is dropped and none is repeated.
- R3: An entry for tile (tx, ty) appears only on pipe (tx + ty) mod NUM_PIPES.
- R4: A cycle with cfg_wr=1 loads cfg_tile_log2 (values 0 to 7) as the tile log2 used for primitives accepted afterwards.
- R5: Each pipe FIFO drains independently through its own pipe_rd. Within one pipe, entries arrive in primitive order, and within a primitive they arrive in row-major order (x fastest). The head entry holds steady until it is read.
- R6: in_ready is 0 while a walk is in progress. When the FIFO of the current tile's owner is full, the walk waits on that tile until the FIFO has room, and no entry is lost.
- R7: When chip_log2 is nonzero, a tile is emitted only if ((tx>>SUPER_LOG2) + (ty>>SUPER_LOG2)) mod 2^chip_log2 equals chip_id. The default SUPER_LOG2 is 2. Other tiles are skipped. When chip_log2 is 0, the filter is off.
- R8: A box with min_x > max_x, min_y > max_y, min_x >= SCREEN_W or min_y >= SCREEN_H produces no entry. It is consumed in its handshake cycle, and in_ready stays 1 on the following cycle.
- R9: Pipe p's entry is pipe_entry[p*32 +: 32]. Bits [31:24] hold the primitive ID, bits [23:12] hold tile_y and bits [11:0] hold tile_x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Loads cfg_tile_log2 into the tile size setting |
| cfg_tile_log2 | input | 3 | New tile edge length as a log2 value |
| chip_id | input | 3 | This chip's index in the split-frame group |
| chip_log2 | input | 2 | log2 of the chip count; 0 turns off the ownership filter |
| in_valid | input | 1 | A primitive is offered |
| in_ready | output | 1 | The distributor can take a primitive |
| in_prim | input | 8 | Primitive identifier |
| in_min_x | input | 12 | Bounding box left pixel |
| in_min_y | input | 12 | Bounding box top pixel |
| in_max_x | input | 12 | Bounding box right pixel (inclusive) |
| in_max_y | input | 12 | Bounding box bottom pixel (inclusive) |
| pipe_rd | input | NUM_PIPES | Per-pipe read of the head entry |
| pipe_valid | output | NUM_PIPES | Per-pipe head entry present |
| pipe_entry | output | NUM_PIPES*32 | Per-pipe head entries, packed as in R9 |

## Verification
The checker watches every cycle for several properties. It flags any pipe head that holds a tile of the wrong pipe or of another chip. It flags any write into a full FIFO and any cycle that writes to more than one pipe. It also checks that a head entry not read stays put, and that an empty or inverted box leaves the input ready. Whether each box yields exactly its clamped tile set, in the right per-pipe order, can only be shown by the bench scenarios. The same holds for a reprogrammed tile size taking effect and for a stalled walk later delivering every tile. The bench compares each drained entry against a queue built from the requirements.

// File: rtl/tdist_pkg.sv
package tdist_pkg;

    parameter int TD_COORD_W   = 12;
    parameter int TD_PRIM_W    = 8;
    parameter int TD_SHIFT_W   = 3;
    parameter int TD_CHIP_W    = 3;
    parameter int TD_CHIPLOG_W = 2;

    localparam logic [TD_SHIFT_W-1:0] TD_SHIFT_RST = TD_SHIFT_W'(4);

    typedef logic [TD_COORD_W-1:0] coord_t;
    typedef logic [TD_PRIM_W-1:0]  prim_t;

    typedef struct packed {
        prim_t  prim;
        coord_t ty;
        coord_t tx;
    } tile_entry_t;

    typedef struct packed {
        prim_t  prim;
        coord_t x0;
        coord_t y0;
        coord_t x1;
        coord_t y1;
    } bbox_t;

    typedef struct packed {
        prim_t  prim;
        coord_t tx0;
        coord_t ty0;
        coord_t tx1;
        coord_t ty1;
    } span_t;

    typedef enum logic {
        WK_IDLE,
        WK_WALK
    } walk_state_e;

    // Chip that owns the supertile holding tile (tx, ty).
    function automatic logic [TD_CHIP_W-1:0] super_owner(
        input coord_t                  tx,
        input coord_t                  ty,
        input int unsigned             sup,
        input logic [TD_CHIPLOG_W-1:0] clog
    );
        coord_t                sx;
        coord_t                sy;
        logic [TD_COORD_W:0]   sum;
        logic [TD_CHIP_W-1:0]  msk;
        sx  = tx >> sup;
        sy  = ty >> sup;
        sum = {1'b0, sx} + {1'b0, sy};
        msk = ~({TD_CHIP_W{1'b1}} << clog);
        return sum[TD_CHIP_W-1:0] & msk;
    endfunction

endpackage

// File: rtl/tdist_range.sv
module tdist_range
    import tdist_pkg::*;
#(
    parameter int SCREEN_W = 640,
    parameter int SCREEN_H = 480
) (
    input  bbox_t                  box,
    input  logic [TD_SHIFT_W-1:0]  shift,
    output span_t                  span,
    output logic                   empty
);

    localparam coord_t X_LAST = coord_t'(SCREEN_W - 1);
    localparam coord_t Y_LAST = coord_t'(SCREEN_H - 1);

    coord_t x1c;
    coord_t y1c;
    logic   off_screen;
    logic   inverted;

    always_comb begin
        x1c        = (box.x1 > X_LAST) ? X_LAST : box.x1;
        y1c        = (box.y1 > Y_LAST) ? Y_LAST : box.y1;
        off_screen = (box.x0 > X_LAST) || (box.y0 > Y_LAST);
        inverted   = (box.x0 > box.x1) || (box.y0 > box.y1);
        empty      = off_screen || inverted;

        span.prim  = box.prim;
        span.tx0   = box.x0 >> shift;
        span.ty0   = box.y0 >> shift;
        span.tx1   = x1c >> shift;
        span.ty1   = y1c >> shift;
    end

endmodule

// File: rtl/tdist_walker.sv
module tdist_walker
    import tdist_pkg::*;
#(
    parameter int NUM_PIPES  = 4,
    parameter int SUPER_LOG2 = 2,
    localparam int PIPE_W    = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  span_t                    span_in,
    input  logic                     span_empty,
    input  logic [TD_CHIP_W-1:0]     chip_id,
    input  logic [TD_CHIPLOG_W-1:0]  chip_log2,
    input  logic [NUM_PIPES-1:0]     pipe_full,
    output logic [NUM_PIPES-1:0]     walk_push,
    output tile_entry_t              walk_entry
);

    walk_state_e         state;
    span_t               span_q;
    coord_t              cx;
    coord_t              cy;
    logic [TD_COORD_W:0] tsum;
    logic [PIPE_W-1:0]   pipe_sel;
    logic                owned;
    logic                blocked;
    logic                advance;
    logic                last_col;
    logic                last_row;

    always_comb begin
        tsum     = {1'b0, cx} + {1'b0, cy};
        pipe_sel = PIPE_W'(tsum % (TD_COORD_W + 1)'(NUM_PIPES));
        owned    = (chip_log2 == '0) ||
                   (super_owner(cx, cy, SUPER_LOG2, chip_log2) == chip_id);
        blocked  = owned && pipe_full[pipe_sel];
        advance  = (state == WK_WALK) && !blocked;
        last_col = (cx == span_q.tx1);
        last_row = (cy == span_q.ty1);
        in_ready = (state == WK_IDLE);

        walk_push = '0;
        if (advance && owned) begin
            walk_push[pipe_sel] = 1'b1;
        end
        walk_entry.prim = span_q.prim;
        walk_entry.tx   = cx;
        walk_entry.ty   = cy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= WK_IDLE;
            span_q <= '0;
            cx     <= '0;
            cy     <= '0;
        end else begin
            case (state)
                WK_IDLE: begin
                    if (in_valid && !span_empty) begin
                        span_q <= span_in;
                        cx     <= span_in.tx0;
                        cy     <= span_in.ty0;
                        state  <= WK_WALK;
                    end
                end
                WK_WALK: begin
                    if (advance) begin
                        if (last_col) begin
                            if (last_row) begin
                                state <= WK_IDLE;
                            end else begin
                                cx <= span_q.tx0;
                                cy <= cy + 1'b1;
                            end
                        end else begin
                            cx <= cx + 1'b1;
                        end
                    end
                end
                default: state <= WK_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tdist_fifo.sv
module tdist_fifo
    import tdist_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  tile_entry_t din,
    input  logic        pop,
    output tile_entry_t dout,
    output logic        valid,
    output logic        full
);

    tile_entry_t     mem [DEPTH];
    logic [AW-1:0]   wp;
    logic [AW-1:0]   rp;
    logic [AW:0]     cnt;
    logic            do_push;
    logic            do_pop;

    always_comb begin
        full    = (cnt == (AW + 1)'(DEPTH));
        valid   = (cnt != '0);
        do_push = push && !full;
        do_pop  = pop && valid;
        dout    = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop) begin
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/tile_distributor.sv
module tile_distributor
    import tdist_pkg::*;
#(
    parameter int NUM_PIPES  = 4,
    parameter int FIFO_DEPTH = 8,
    parameter int SCREEN_W   = 640,
    parameter int SCREEN_H   = 480,
    parameter int SUPER_LOG2 = 2,
    localparam int EW        = $bits(tile_entry_t)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_wr,
    input  logic [TD_SHIFT_W-1:0]    cfg_tile_log2,
    input  logic [TD_CHIP_W-1:0]     chip_id,
    input  logic [TD_CHIPLOG_W-1:0]  chip_log2,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [TD_PRIM_W-1:0]     in_prim,
    input  logic [TD_COORD_W-1:0]    in_min_x,
    input  logic [TD_COORD_W-1:0]    in_min_y,
    input  logic [TD_COORD_W-1:0]    in_max_x,
    input  logic [TD_COORD_W-1:0]    in_max_y,
    input  logic [NUM_PIPES-1:0]     pipe_rd,
    output logic [NUM_PIPES-1:0]     pipe_valid,
    output logic [NUM_PIPES*EW-1:0]  pipe_entry
);

    logic [TD_SHIFT_W-1:0] tile_log2_q;
    bbox_t                 box;
    span_t                 span;
    logic                  box_empty;
    logic [NUM_PIPES-1:0]  pipe_full;
    logic [NUM_PIPES-1:0]  walk_push;
    tile_entry_t           walk_entry;

    always_ff @(posedge clk) begin
        if (rst) begin
            tile_log2_q <= TD_SHIFT_RST;
        end else if (cfg_wr) begin
            tile_log2_q <= cfg_tile_log2;
        end
    end

    always_comb begin
        box.prim = in_prim;
        box.x0   = in_min_x;
        box.y0   = in_min_y;
        box.x1   = in_max_x;
        box.y1   = in_max_y;
    end

    tdist_range #(
        .SCREEN_W (SCREEN_W),
        .SCREEN_H (SCREEN_H)
    ) u_range (
        .box   (box),
        .shift (tile_log2_q),
        .span  (span),
        .empty (box_empty)
    );

    tdist_walker #(
        .NUM_PIPES  (NUM_PIPES),
        .SUPER_LOG2 (SUPER_LOG2)
    ) u_walker (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .span_in    (span),
        .span_empty (box_empty),
        .chip_id    (chip_id),
        .chip_log2  (chip_log2),
        .pipe_full  (pipe_full),
        .walk_push  (walk_push),
        .walk_entry (walk_entry)
    );

    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
        tile_entry_t head;

        tdist_fifo #(
            .DEPTH (FIFO_DEPTH)
        ) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (walk_push[p]),
            .din   (walk_entry),
            .pop   (pipe_rd[p]),
            .dout  (head),
            .valid (pipe_valid[p]),
            .full  (pipe_full[p])
        );

        assign pipe_entry[p*EW +: EW] = head;
    end

endmodule

// File: rtl/tdist_checker.sv
module tdist_checker
    import tdist_pkg::*;
#(
    parameter int NUM_PIPES  = 4,
    parameter int SUPER_LOG2 = 2,
    localparam int EW        = $bits(tile_entry_t)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     in_ready,
    input  logic [TD_COORD_W-1:0]    in_min_x,
    input  logic [TD_COORD_W-1:0]    in_min_y,
    input  logic [TD_COORD_W-1:0]    in_max_x,
    input  logic [TD_COORD_W-1:0]    in_max_y,
    input  logic [TD_CHIP_W-1:0]     chip_id,
    input  logic [TD_CHIPLOG_W-1:0]  chip_log2,
    input  logic [NUM_PIPES-1:0]     pipe_rd,
    input  logic [NUM_PIPES-1:0]     pipe_valid,
    input  logic [NUM_PIPES*EW-1:0]  pipe_entry,
    input  logic [NUM_PIPES-1:0]     walk_push,
    input  logic [NUM_PIPES-1:0]     pipe_full
);

    AST_SINGLE_PUSH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(walk_push)); // R2

    AST_INVERTED_BOX: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && ((in_min_x > in_max_x) || (in_min_y > in_max_y)))
        |=> in_ready); // R8

    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_chk
        tile_entry_t ent;
        assign ent = pipe_entry[p*EW +: EW];

        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            walk_push[p] |-> !pipe_full[p]); // R6

        AST_PIPE_OWNER: assert property (@(posedge clk) disable iff (rst)
            pipe_valid[p] |-> (((int'(ent.tx) + int'(ent.ty)) % NUM_PIPES) == p)); // R3

        AST_CHIP_OWNER: assert property (@(posedge clk) disable iff (rst)
            (pipe_valid[p] && (chip_log2 != '0)) |->
            ((((int'(ent.tx) >> SUPER_LOG2) + (int'(ent.ty) >> SUPER_LOG2))
              % (1 << chip_log2)) == int'(chip_id))); // R7

        AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
            (pipe_valid[p] && !pipe_rd[p]) |=>
            (pipe_valid[p] && $stable(pipe_entry[p*EW +: EW]))); // R5
    end

endmodule

bind tile_distributor tdist_checker #(
    .NUM_PIPES  (NUM_PIPES),
    .SUPER_LOG2 (SUPER_LOG2)
) u_tdist_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_min_x   (in_min_x),
    .in_min_y   (in_min_y),
    .in_max_x   (in_max_x),
    .in_max_y   (in_max_y),
    .chip_id    (chip_id),
    .chip_log2  (chip_log2),
    .pipe_rd    (pipe_rd),
    .pipe_valid (pipe_valid),
    .pipe_entry (pipe_entry),
    .walk_push  (walk_push),
    .pipe_full  (pipe_full)
);

// File: tb/tile_distributor_bench.sv
module tile_distributor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 4;
    localparam int EW         = 32;
    localparam int QD         = 256;
    localparam int SCR_W      = 640;
    localparam int SCR_H      = 480;
    localparam int SUP        = 2;

    logic            clk = 1'b0;
    logic            rst;
    logic            cfg_wr;
    logic [2:0]      cfg_tile_log2;
    logic [2:0]      chip_id;
    logic [1:0]      chip_log2;
    logic            in_valid;
    logic            in_ready;
    logic [7:0]      in_prim;
    logic [11:0]     in_min_x, in_min_y, in_max_x, in_max_y;
    logic [NP-1:0]   pipe_rd;
    logic [NP-1:0]   pipe_valid;
    logic [NP*EW-1:0] pipe_entry;

    int checks   = 0;
    int failures = 0;
    int cur_log2 = 4;
    int m_chip_log2 = 0;
    int m_chip_id   = 0;

    int q_prim [NP][QD];
    int q_tx   [NP][QD];
    int q_ty   [NP][QD];
    int q_head [NP];
    int q_tail [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    tile_distributor u_tile_distributor (
        .clk           (clk),
        .rst           (rst),
        .cfg_wr        (cfg_wr),
        .cfg_tile_log2 (cfg_tile_log2),
        .chip_id       (chip_id),
        .chip_log2     (chip_log2),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_prim       (in_prim),
        .in_min_x      (in_min_x),
        .in_min_y      (in_min_y),
        .in_max_x      (in_max_x),
        .in_max_y      (in_max_y),
        .pipe_rd       (pipe_rd),
        .pipe_valid    (pipe_valid),
        .pipe_entry    (pipe_entry)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic q_clear();
        for (int p = 0; p < NP; p++) begin
            q_head[p] = 0;
            q_tail[p] = 0;
        end
    endtask

    // Expected tile set of one box, from the requirements.
    task automatic model_prim(input int prim, input int x0, input int y0,
                              input int x1, input int y1);
        int cx1, cy1, p;
        if (x0 > x1 || y0 > y1 || x0 >= SCR_W || y0 >= SCR_H) return;
        cx1 = (x1 > SCR_W - 1) ? SCR_W - 1 : x1;
        cy1 = (y1 > SCR_H - 1) ? SCR_H - 1 : y1;
        for (int ty = (y0 >> cur_log2); ty <= (cy1 >> cur_log2); ty++) begin
            for (int tx = (x0 >> cur_log2); tx <= (cx1 >> cur_log2); tx++) begin
                if (m_chip_log2 == 0 ||
                    (((tx >> SUP) + (ty >> SUP)) % (1 << m_chip_log2)) == m_chip_id) begin
                    p = (tx + ty) % NP;
                    q_prim[p][q_tail[p]] = prim;
                    q_tx[p][q_tail[p]]   = tx;
                    q_ty[p][q_tail[p]]   = ty;
                    q_tail[p]++;
                end
            end
        end
    endtask

    task automatic send(input int prim, input int x0, input int y0,
                        input int x1, input int y1);
        model_prim(prim, x0, y0, x1, y1);
        @(negedge clk);
        in_prim  = 8'(prim);
        in_min_x = 12'(x0);
        in_min_y = 12'(y0);
        in_max_x = 12'(x1);
        in_max_y = 12'(y1);
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic set_log2(input int v);
        @(negedge clk);
        cfg_wr        = 1'b1;
        cfg_tile_log2 = 3'(v);
        @(negedge clk);
        cfg_wr   = 1'b0;
        cur_log2 = v;
    endtask

    // Read the selected pipes, compare each entry with the expected queue head.
    task automatic drain(input logic [NP-1:0] mask, input string tag);
        int  guard = 0;
        bit  done  = 0;
        logic [EW-1:0] e;
        while (!done) begin
            @(negedge clk);
            pipe_rd = '0;
            if (in_ready && ((pipe_valid & mask) == '0)) begin
                done = 1;
            end else begin
                for (int p = 0; p < NP; p++) begin
                    if (mask[p] && pipe_valid[p]) begin
                        e = pipe_entry[p*EW +: EW];
                        if (q_head[p] == q_tail[p]) begin
                            chk(0, tag, $sformatf("pipe %0d extra entry tx", p),
                                int'(e[11:0]), -1);
                        end else begin
                            chk(int'(e[31:24]) == q_prim[p][q_head[p]], "R9",
                                $sformatf("%s pipe %0d prim", tag, p),
                                int'(e[31:24]), q_prim[p][q_head[p]]);
                            chk(int'(e[11:0]) == q_tx[p][q_head[p]], tag,
                                $sformatf("pipe %0d tile_x", p),
                                int'(e[11:0]), q_tx[p][q_head[p]]);
                            chk(int'(e[23:12]) == q_ty[p][q_head[p]], tag,
                                $sformatf("pipe %0d tile_y", p),
                                int'(e[23:12]), q_ty[p][q_head[p]]);
                            q_head[p]++;
                        end
                        pipe_rd[p] = 1'b1;
                    end
                end
                guard++;
                if (guard > 3000) begin
                    chk(0, tag, "drain timeout", guard, 0);
                    done = 1;
                end
            end
        end
        pipe_rd = '0;
        for (int p = 0; p < NP; p++) begin
            if (mask[p]) begin
                chk(q_head[p] == q_tail[p], tag,
                    $sformatf("pipe %0d entries remaining", p),
                    q_tail[p] - q_head[p], 0);
            end
        end
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        chk(pipe_valid == '0, "R1", "pipe_valid after reset", int'(pipe_valid), 0);
        q_clear();
        // 16-pixel default: 32x16 box covers tiles (0,0) and (1,0)
        send(1, 0, 0, 31, 15);
        drain('1, "R1");
        chk(q_tail[0] == 1 && q_tail[1] == 1, "R1", "default tile count pipe0+1",
            q_tail[0] + q_tail[1], 2);
        q_clear();
    endtask

    task automatic t_single();
        send(2, 35, 37, 40, 44);
        drain('1, "R2");
        chk(q_tail[0] + q_tail[1] + q_tail[2] + q_tail[3] == 1, "R2",
            "single tile entry count", q_tail[0] + q_tail[1] + q_tail[2] + q_tail[3], 1);
        q_clear();
    endtask

    task automatic t_multi();
        send(3, 20, 10, 60, 40);
        drain('1, "R3");
        q_clear();
    endtask

    task automatic t_clip();
        send(4, 600, 460, 900, 700);
        drain('1, "R2");
        chk(q_tail[0] + q_tail[1] + q_tail[2] + q_tail[3] == 6, "R2",
            "clipped tile count", q_tail[0] + q_tail[1] + q_tail[2] + q_tail[3], 6);
        q_clear();
    endtask

    task automatic t_resize();
        set_log2(3);
        send(5, 5, 3, 20, 9);
        drain('1, "R4");
        chk(q_tail[0] + q_tail[1] + q_tail[2] + q_tail[3] == 6, "R4",
            "8px tile count", q_tail[0] + q_tail[1] + q_tail[2] + q_tail[3], 6);
        q_clear();
        set_log2(7);
        send(6, 100, 0, 300, 200);
        drain('1, "R4");
        q_clear();
        set_log2(4);
    endtask

    task automatic t_order();
        send(10, 0, 0, 47, 15);
        send(11, 16, 16, 63, 31);
        repeat (6) @(negedge clk);
        drain(4'b1000, "R5");
        chk(pipe_valid[0] == 1'b1, "R5", "pipe0 still holding after pipe3 drain",
            int'(pipe_valid[0]), 1);
        drain('1, "R5");
        q_clear();
    endtask

    task automatic t_stall();
        send(20, 0, 0, 255, 63);
        repeat (40) @(negedge clk);
        chk(in_ready == 1'b0, "R6", "in_ready while stalled", int'(in_ready), 0);
        chk(pipe_valid == '1, "R6", "all pipes holding", int'(pipe_valid), 15);
        drain('1, "R6");
        chk(q_tail[0] == 16 && q_tail[3] == 16, "R6", "tiles per pipe",
            q_tail[0], 16);
        q_clear();
    endtask

    task automatic t_chip();
        @(negedge clk);
        chip_log2   = 2'd1;
        chip_id     = 3'd1;
        m_chip_log2 = 1;
        m_chip_id   = 1;
        send(30, 0, 0, 127, 63);
        drain('1, "R7");
        chk(q_tail[0] + q_tail[1] + q_tail[2] + q_tail[3] == 16, "R7",
            "owned tile count", q_tail[0] + q_tail[1] + q_tail[2] + q_tail[3], 16);
        q_clear();
        @(negedge clk);
        chip_id   = 3'd0;
        m_chip_id = 0;
        send(31, 0, 0, 127, 63);
        drain('1, "R7");
        q_clear();
        @(negedge clk);
        chip_log2   = 2'd0;
        m_chip_log2 = 0;
    endtask

    task automatic t_empty_box(input int x0, input int y0, input int x1, input int y1);
        @(negedge clk);
        in_prim  = 8'd40;
        in_min_x = 12'(x0);
        in_min_y = 12'(y0);
        in_max_x = 12'(x1);
        in_max_y = 12'(y1);
        in_valid = 1'b1;
        chk(in_ready == 1'b1, "R8", "ready before empty box", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b1, "R8", "ready after empty box", int'(in_ready), 1);
        repeat (3) @(negedge clk);
        chk(pipe_valid == '0, "R8", "no entries for empty box", int'(pipe_valid), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst           = 1'b1;
        cfg_wr        = 1'b0;
        cfg_tile_log2 = 3'd0;
        chip_id       = 3'd0;
        chip_log2     = 2'd0;
        in_valid      = 1'b0;
        in_prim       = '0;
        in_min_x      = '0;
        in_min_y      = '0;
        in_max_x      = '0;
        in_max_y      = '0;
        pipe_rd       = '0;
        q_clear();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        t_reset();
        t_single();
        t_multi();
        t_clip();
        t_resize();
        t_order();
        t_stall();
        t_chip();
        t_empty_box(700, 10, 720, 20);
        t_empty_box(10, 500, 20, 520);
        t_empty_box(50, 10, 20, 30);
        t_empty_box(10, 40, 30, 20);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule